// File: doc/BRIEF.md
# Gated Countdown Event Timer

This block is a single 32-bit countdown event timer driven through a small memory-mapped register port with an APB-style transfer. Software programs it through two registers: a control word and a timeout word. Storing a timeout starts a countdown that advances once per clock in which the `tick_en` input is high. When the countdown reaches zero, the counter halts and a pending flag is set. The `irq` output is high while that flag is set and the interrupt is enabled.

The run bit in the control word acts as a gate as well as an on/off switch. Unless it is already set, a new timeout is discarded, the interrupt enable cannot be raised, and a clear request does nothing. Clearing the run bit stops an active countdown. The count keeps its value but does not resume, so only a fresh timeout starts the timer again. A typical acknowledge sequence sets the run bit and the clear bit in one write. This removes the pending event and leaves the interrupt disabled until it is re-armed.

Top module: `sys_countdown_timer`

## Requirements
- R1: After reset the run bit, interrupt enable, pending flag and count are all zero, `irq` is low, and both registers read as zero.
- R2: The control register sits at byte offset 0x40. Its bit 0 is the run bit, bit 1 the interrupt enable and bit 4 the clear request. A read returns the run bit in bit 0 and the enable in bit 1, with every other bit zero, because the clear request never reads back as set.
- R3: The timeout register sits at byte offset 0x44. A write to it while the run bit is set loads the count and starts the countdown. A read returns the current remaining count.
- R4: While the run bit is set and a countdown is active, the count falls by one on each clock with `tick_en` high. It holds its value on clocks with `tick_en` low.
- R5: When an active countdown reaches zero, the pending flag is set and the count stays at zero whatever `tick_en` does.
- R6: `irq` is high exactly when the pending flag is set and the interrupt enable is set.
- R7: A write to the timeout register while the run bit is clear is ignored, and the count is unchanged.
- R8: The interrupt enable becomes 1 only through a control write that has bits 0 and 1 set while the run bit is already set. Any control write clears it otherwise, and a control write with bit 0 clear clears both bits.
- R9: A control write with bit 4 set while the run bit is set clears the pending flag. When that write has bit 1 clear, the interrupt is left disabled.
- R10: A clear request takes priority over a countdown that reaches zero on the same clock, so the pending flag ends up clear.
- R11: Writing zero to the control register stops the countdown. The count is frozen, no expiry follows, and setting the run bit again does not resume it.
- R12: The full 32-bit range is accepted: 0xFFFFFFFF loads and counts down to 0xFFFFFFFE after one tick.
- R13: Loading a timeout of zero while running sets the pending flag on the following clock, with no tick needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count strobe: one decrement per clock while high |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a selected read |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the gating rules. A timeout or an interrupt-enable written while stopped must leave no trace. A design that ignored the gate would show a count or raise `irq` after the run bit was set later. It checks that the clear request and a zero-reach on the same clock leave `irq` low, where a wrong priority would leave an interrupt stuck high. It loads a zero timeout, loads the full 32-bit maximum, ticks past zero and stops with resume attempts. These expose an off-by-one expiry, a truncated counter, a counter that wraps below zero, and a timer that restarts by itself. Randomized timeout and tick counts are then compared against a model of remaining count and pending state.

// File: rtl/sct_pkg.sv
// Package: shared field positions and decode type for the countdown timer.
// Assumes a 32-bit register word; bit positions are fixed by the software view.
package sct_pkg;
    localparam int unsigned RUN_BIT = 0;
    localparam int unsigned IEN_BIT = 1;
    localparam int unsigned CLR_BIT = 4;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_tmo;
    } sct_wr_t;
endpackage

// File: rtl/sct_bus_decode.sv
// Module: register port decode. Turns an APB-style access phase into
// one-cycle write strobes and muxes the read data. Assumes transfers with
// no wait states; prdata is zero outside a selected read.
module sct_bus_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h40,
    parameter logic [ADDR_W-1:0] TMO_OFF  = 8'h44
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] ctrl_rd,
    input  logic [DATA_W-1:0] cnt_rd,
    output sct_pkg::sct_wr_t  wr,
    output logic [DATA_W-1:0] prdata
);
    logic access_wr;
    logic access_rd;

    // Purpose: qualify the access phase of a transfer.
    always_comb begin
        access_wr = psel & penable & pwrite;
        access_rd = psel & ~pwrite;
    end

    // Purpose: produce register write strobes.
    always_comb begin
        wr.wr_ctrl = access_wr & (paddr == CTRL_OFF);
        wr.wr_tmo  = access_wr & (paddr == TMO_OFF);
    end

    // Purpose: select read data by offset.
    always_comb begin
        prdata = '0;
        if (access_rd) begin
            if (paddr == CTRL_OFF)      prdata = ctrl_rd;
            else if (paddr == TMO_OFF)  prdata = cnt_rd;
        end
    end
endmodule

// File: rtl/sct_ctrl_regs.sv
// Module: control state. Holds the run bit, interrupt enable and pending
// flag. The run bit already held gates every interrupt-side change; a
// clear request beats a same-cycle expiry.
module sct_ctrl_regs #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output logic              run_en,
    output logic              irq_en,
    output logic              pending,
    output logic              stop,
    output logic [DATA_W-1:0] ctrl_rd
);
    import sct_pkg::*;

    logic clear_req;

    // Purpose: decode a gated clear and a stop request from a control write.
    always_comb begin
        clear_req = wr_ctrl & run_en & wdata[CLR_BIT];
        stop      = wr_ctrl & ~wdata[RUN_BIT];
    end

    // Purpose: update run bit and gated interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en <= 1'b0;
            irq_en <= 1'b0;
        end else if (wr_ctrl) begin
            run_en <= wdata[RUN_BIT];
            irq_en <= run_en & wdata[RUN_BIT] & wdata[IEN_BIT];
        end
    end

    // Purpose: pending flag, clear has priority over expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= 1'b0;
        else if (clear_req) pending <= 1'b0;
        else if (expire)    pending <= 1'b1;
    end

    // Purpose: assemble control read-back word.
    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[RUN_BIT] = run_en;
        ctrl_rd[IEN_BIT] = irq_en;
    end
endmodule

// File: rtl/sct_down_counter.sv
// Module: the countdown itself. Loads on a gated timeout write, decrements
// per tick while running, halts at zero and flags expiry for one cycle.
// Assumes load and stop never arrive together (single register port).
module sct_down_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             stop,
    output logic [CNT_W-1:0] count,
    output logic             active,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic load_ok;
    logic step;

    // Purpose: gated load, decrement step and expiry detect.
    always_comb begin
        load_ok = load & run_en;
        step    = run_en & active & tick_en & (count != '0);
        expire  = ~load_ok & run_en & active &
                  ((count == '0) | (tick_en & (count == ONE)));
    end

    // Purpose: count register and active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            active <= 1'b0;
        end else if (load_ok) begin
            count  <= load_val;
            active <= 1'b1;
        end else begin
            if (stop || expire) active <= 1'b0;
            if (step)           count  <= count - ONE;
        end
    end
endmodule

// File: rtl/sys_countdown_timer.sv
// Module: top of the gated countdown event timer. Connects register decode,
// control state and counter; irq is pending qualified by the enable.
// Assumes a single clock domain and a synchronous active-low reset.
module sys_countdown_timer #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h40,
    parameter logic [ADDR_W-1:0] TMO_OFF  = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq
);
    sct_pkg::sct_wr_t  wr;
    logic [DATA_W-1:0] ctrl_rd;
    logic [DATA_W-1:0] count;
    logic              run_en;
    logic              irq_en;
    logic              pending;
    logic              stop;
    logic              active;
    logic              expire;

    sct_bus_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CTRL_OFF(CTRL_OFF), .TMO_OFF(TMO_OFF)
    ) u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .ctrl_rd(ctrl_rd), .cnt_rd(count), .wr(wr), .prdata(prdata)
    );

    sct_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr.wr_ctrl), .wdata(pwdata),
        .expire(expire), .run_en(run_en), .irq_en(irq_en),
        .pending(pending), .stop(stop), .ctrl_rd(ctrl_rd)
    );

    sct_down_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick_en(tick_en),
        .load(wr.wr_tmo), .load_val(pwdata), .stop(stop),
        .count(count), .active(active), .expire(expire)
    );

    // Purpose: interrupt output.
    always_comb irq = pending & irq_en;
endmodule

// File: rtl/sys_countdown_timer_checker.sv
// Module: property checker bound to the timer top.
module sys_countdown_timer_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h40,
    parameter logic [ADDR_W-1:0] TMO_OFF  = 8'h44
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic              irq,
    input logic              run_en,
    input logic              irq_en,
    input logic              pending,
    input logic              active,
    input logic [DATA_W-1:0] count
);
    logic wr_ctrl_c;
    logic wr_tmo_c;

    always_comb begin
        wr_ctrl_c = psel & penable & pwrite & (paddr == CTRL_OFF);
        wr_tmo_c  = psel & penable & pwrite & (paddr == TMO_OFF);
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_tmo_c) |=> $stable(count));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && active && tick_en && count != '0 && !wr_tmo_c)
        |=> count == $past(count) - 1);

    p_zero_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !(wr_tmo_c && run_en)) |=> count == '0);

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || !pending) |-> !irq);

    p_tmo_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tmo_c && !run_en) |=> $stable(count));

    p_ien_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !irq_en);

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_c && run_en && pwdata[4]) |=> (!pending && !irq));

    p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_c && !pwdata[0]) |=> (!run_en && !active));
endmodule

bind sys_countdown_timer sys_countdown_timer_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFF(CTRL_OFF), .TMO_OFF(TMO_OFF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .irq(irq), .run_en(run_en), .irq_en(irq_en), .pending(pending),
    .active(active), .count(count)
);

// File: tb/test_sys_countdown_timer.sv
module test_sys_countdown_timer;
    localparam logic [7:0] CTRL = 8'h40;
    localparam logic [7:0] TMO  = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sys_countdown_timer i_sys_countdown_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel),
        .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq(irq)
    );

    function automatic logic [31:0] exp_count(logic [31:0] v, int n);
        return (v <= 32'(n)) ? 32'd0 : v - 32'(n);
    endfunction

    function automatic logic exp_pend(logic [31:0] v, int n);
        return (v == 32'd0) || (32'(n) >= v);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_write(logic [7:0] a, logic [31:0] d, bit tick_in_access);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        if (tick_in_access) tick_en = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; tick_en = 1'b0;
    endtask

    task automatic apb_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic run_ticks(int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic irq_now(output logic v);
        @(negedge clk);
        #1 v = irq;
    endtask

    initial begin
        logic [31:0] rd;
        logic        iv;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        apb_read(CTRL, rd); check("R1 ctrl after reset", rd, 32'h0);
        apb_read(TMO, rd);  check("R1 count after reset", rd, 32'h0);
        irq_now(iv);        check("R1 irq after reset", {31'd0, iv}, 32'd0);

        // R7 timeout write while stopped is ignored
        apb_write(TMO, 32'd55, 1'b0);
        apb_read(TMO, rd); check("R7 ignored timeout", rd, 32'h0);

        // R8 enable cannot be raised in the write that sets run
        apb_write(CTRL, 32'h3, 1'b0);
        apb_read(CTRL, rd); check("R8 ien gated", rd, 32'h1);
        // R2 fields read back, clear bit reads zero
        apb_write(CTRL, 32'h13, 1'b0);
        apb_read(CTRL, rd); check("R2 ctrl readback", rd, 32'h3);

        // R3 load and read back; R4 hold without tick
        apb_write(TMO, 32'd20, 1'b0);
        apb_read(TMO, rd); check("R3 loaded count", rd, 32'd20);
        repeat (10) @(negedge clk);
        apb_read(TMO, rd); check("R4 hold without tick", rd, 32'd20);
        run_ticks(5);
        apb_read(TMO, rd); check("R4 five ticks", rd, 32'd15);

        // R11 stop freezes and does not resume
        apb_write(CTRL, 32'h0, 1'b0);
        apb_read(CTRL, rd); check("R11 ctrl after stop", rd, 32'h0);
        run_ticks(30);
        apb_read(TMO, rd); check("R11 frozen count", rd, 32'd15);
        apb_write(CTRL, 32'h1, 1'b0);
        apb_write(CTRL, 32'h3, 1'b0);
        run_ticks(30);
        apb_read(TMO, rd); check("R11 no resume", rd, 32'd15);
        irq_now(iv); check("R11 no expiry", {31'd0, iv}, 32'd0);

        // R5 expiry halts at zero; R6 irq follows pending and enable
        apb_write(TMO, 32'd4, 1'b0);
        run_ticks(3);
        irq_now(iv); check("R5 not yet expired", {31'd0, iv}, 32'd0);
        run_ticks(10);
        apb_read(TMO, rd); check("R5 count stays zero", rd, 32'd0);
        irq_now(iv); check("R6 irq with pending and enable", {31'd0, iv}, 32'd1);

        // R9 clear with enable bit low leaves interrupt disabled
        apb_write(CTRL, 32'h11, 1'b0);
        irq_now(iv); check("R9 irq after clear", {31'd0, iv}, 32'd0);
        apb_read(CTRL, rd); check("R9 ien off after clear", rd, 32'h1);
        apb_write(CTRL, 32'h3, 1'b0);
        irq_now(iv); check("R9 pending gone", {31'd0, iv}, 32'd0);

        // R6 pending held while enable is off
        apb_write(CTRL, 32'h1, 1'b0);
        apb_write(TMO, 32'd2, 1'b0);
        run_ticks(2);
        irq_now(iv); check("R6 masked pending", {31'd0, iv}, 32'd0);
        apb_write(CTRL, 32'h3, 1'b0);
        irq_now(iv); check("R6 unmasked pending", {31'd0, iv}, 32'd1);

        // R12 full-range value
        apb_write(CTRL, 32'h13, 1'b0);
        apb_write(TMO, 32'hFFFF_FFFF, 1'b0);
        run_ticks(1);
        apb_read(TMO, rd); check("R12 max value tick", rd, 32'hFFFF_FFFE);

        // R13 zero load expires without tick
        apb_write(TMO, 32'd0, 1'b0);
        irq_now(iv); check("R13 zero load expiry", {31'd0, iv}, 32'd1);

        // R10 clear wins over same-cycle expiry
        apb_write(CTRL, 32'h13, 1'b0);
        apb_write(TMO, 32'd1, 1'b0);
        apb_write(CTRL, 32'h13, 1'b1);
        irq_now(iv); check("R10 clear beats expiry", {31'd0, iv}, 32'd0);
        apb_read(TMO, rd); check("R10 count reached zero", rd, 32'd0);

        // Random: R3 R4 R5 against bench model
        for (int i = 0; i < 40; i++) begin
            logic [31:0] v;
            int n;
            v = ($urandom % 4 == 0) ? $urandom : ($urandom % 48);
            n = int'($urandom % 48);
            apb_write(CTRL, 32'h1, 1'b0);
            apb_write(CTRL, 32'h11, 1'b0);
            apb_write(CTRL, 32'h3, 1'b0);
            apb_write(TMO, v, 1'b0);
            run_ticks(n);
            apb_read(TMO, rd); check("R4 random count", rd, exp_count(v, n));
            irq_now(iv); check("R5 random pending", {31'd0, iv}, {31'd0, exp_pend(v, n)});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule